// File: doc/BRIEF.md
# Dual-Port RAM with Per-Port Write Modes

This block is a synchronous dual-port memory. Two ports, A and B, share one storage array, and each port can read or write in every cycle. Each port registers its own read data. A static mode parameter on each port sets what that port's read data shows during a write: the word just written, the word that was there before, or the last read word left unchanged.

Each port has an enable. Its write enable and synchronous-init controls only act when the enable is active. Synchronous init loads the port's output register with a constant chosen per port and leaves the stored words alone. Parameters set the polarity of each control and the value that every word holds at power-up. Both ports run on one shared clock. This gives a fixed collision policy: when both ports write the same word in one cycle, the port A data is kept.

Top module: `dual_wmode_ram`

## Requirements
- R1: While `rst` is high at a clock edge, each port's read data is loaded with that port's init constant (`SINIT_A`, `SINIT_B`). Memory writes requested in that cycle still take place.
- R2: Before it is first written, every word reads back as `INIT_WORD`.
- R3: A read is a cycle with the enable active, the write control inactive and the init control inactive. One clock edge later, the port's read data equals the word at the presented address.
- R4: With the port's mode set to write-first (encoding 0), a write cycle stores the data and puts the same data on that port's read output at that edge.
- R5: With the port's mode set to read-first (encoding 1), a write cycle puts the word held before the write on the read output, and stores the new data at the same edge.
- R6: With the port's mode set to no-change (encoding 2), a write cycle stores the data and leaves that port's read output unchanged.
- R7: While a port's enable is inactive, that port writes nothing and its read output holds its value.
- R8: With the enable active and init asserted, the port's read output becomes its init constant. This overrides the mode-based update. A write requested by that port in the same cycle is still stored, and the other port's write is not disturbed.
- R9: Init and write requests on a port whose enable is inactive have no effect.
- R10: With `EN_HIGH`, `WE_HIGH` or `INIT_HIGH` set to 0, the matching control is active when low, and the behaviour is otherwise unchanged.
- R11: Both ports reading the same word in one cycle both receive its correct value.
- R12: When both ports write the same word in one cycle, port A's data is stored.
- R13: When one port writes a word that the other port reads in the same cycle, the written data is stored correctly. The read data of the reading port is undefined for that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shared clock for both ports |
| rst | input | 1 | Synchronous active-high reset of both read registers |
| a_en | input | 1 | Port A enable (polarity from `EN_HIGH`) |
| a_we | input | 1 | Port A write request (polarity from `WE_HIGH`) |
| a_init | input | 1 | Port A synchronous init (polarity from `INIT_HIGH`) |
| a_addr | input | ADDR_W | Port A word address |
| a_wdata | input | DATA_W | Port A write data |
| a_rdata | output | DATA_W | Port A registered read data |
| b_en | input | 1 | Port B enable (polarity from `EN_HIGH`) |
| b_we | input | 1 | Port B write request (polarity from `WE_HIGH`) |
| b_init | input | 1 | Port B synchronous init (polarity from `INIT_HIGH`) |
| b_addr | input | ADDR_W | Port B word address |
| b_wdata | input | DATA_W | Port B write data |
| b_rdata | output | DATA_W | Port B registered read data |

## Verification
The properties assume that every control input holds a known 0 or 1 from the first clock edge, and that reset is high in the first cycles. Without that, the hold, init and write-first checks would compare against undefined values. The bench drives every input to an inactive level at time zero and holds reset for two edges. It changes inputs only on the falling edge. The properties never judge read data in a cycle where the other port writes the same word. The bench skips comparing such read data, except where the port's own write-first or no-change mode fixes its output.

// File: rtl/twp_pkg.sv
`timescale 1ns/1ps
package twp_pkg;

  // Output behaviour of a port during its own write cycle.
  typedef enum logic [1:0] {
    WM_WRITE_FIRST = 2'd0,
    WM_READ_FIRST  = 2'd1,
    WM_NO_CHANGE   = 2'd2
  } wmode_e;

  // Controls of one port after polarity decoding.
  typedef struct packed {
    logic en;
    logic wr;
    logic init;
  } port_cmd_t;

  localparam int NPORTS = 2;

endpackage

// File: rtl/twp_port_ctl.sv
`timescale 1ns/1ps
module twp_port_ctl #(
  parameter bit EN_HIGH   = 1'b1,
  parameter bit WE_HIGH   = 1'b1,
  parameter bit INIT_HIGH = 1'b1
) (
  input  logic                en_raw,
  input  logic                we_raw,
  input  logic                init_raw,
  output twp_pkg::port_cmd_t  cmd
);

  logic en_on;
  logic we_on;
  logic init_on;

  // Polarity folding costs no logic beyond an optional inverter.
  assign en_on   = (en_raw   == EN_HIGH);
  assign we_on   = (we_raw   == WE_HIGH);
  assign init_on = (init_raw == INIT_HIGH);

  // Write and init are both qualified by the enable.
  assign cmd.en   = en_on;
  assign cmd.wr   = en_on & we_on;
  assign cmd.init = en_on & init_on;

endmodule

// File: rtl/twp_array.sv
`timescale 1ns/1ps
module twp_array #(
  parameter int                 DATA_W    = 32,
  parameter int                 ADDR_W    = 10,
  parameter logic [DATA_W-1:0]  INIT_WORD = '0
) (
  input  logic              clk,
  input  logic              wr_a,
  input  logic [ADDR_W-1:0] addr_a,
  input  logic [DATA_W-1:0] din_a,
  input  logic              wr_b,
  input  logic [ADDR_W-1:0] addr_b,
  input  logic [DATA_W-1:0] din_b,
  output logic [DATA_W-1:0] old_a,
  output logic [DATA_W-1:0] old_b
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  // Power-up contents: every word holds the global fill value.
  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = INIT_WORD;
  end

  // Port B is written first and port A last, so on a same-word double write
  // the port A data is what remains.
  always_ff @(posedge clk) begin
    if (wr_b) mem[addr_b] <= din_b;
    if (wr_a) mem[addr_a] <= din_a;
  end

  // Contents before this edge's writes: the source for reads and read-first.
  assign old_a = mem[addr_a];
  assign old_b = mem[addr_b];

endmodule

// File: rtl/twp_dout_reg.sv
`timescale 1ns/1ps
module twp_dout_reg #(
  parameter int                 DATA_W    = 32,
  parameter twp_pkg::wmode_e    MODE      = twp_pkg::WM_WRITE_FIRST,
  parameter logic [DATA_W-1:0]  SINIT_VAL = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  twp_pkg::port_cmd_t cmd,
  input  logic [DATA_W-1:0]  din,
  input  logic [DATA_W-1:0]  old,
  output logic [DATA_W-1:0]  dout
);

  logic [DATA_W-1:0] dout_q;
  logic [DATA_W-1:0] wr_view;

  // The mode parameter picks the output source used on a write cycle.
  generate
    if (MODE == twp_pkg::WM_WRITE_FIRST) begin : g_wf
      assign wr_view = din;
    end else if (MODE == twp_pkg::WM_READ_FIRST) begin : g_rf
      assign wr_view = old;
    end else begin : g_nc
      assign wr_view = dout_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= SINIT_VAL;
    end else if (cmd.en) begin
      if (cmd.init)    dout_q <= SINIT_VAL;
      else if (cmd.wr) dout_q <= wr_view;
      else             dout_q <= old;
    end
  end

  assign dout = dout_q;

endmodule

// File: rtl/dual_wmode_ram.sv
`timescale 1ns/1ps
module dual_wmode_ram #(
  parameter int                 DATA_W    = 32,
  parameter int                 ADDR_W    = 10,
  parameter twp_pkg::wmode_e    MODE_A    = twp_pkg::WM_WRITE_FIRST,
  parameter twp_pkg::wmode_e    MODE_B    = twp_pkg::WM_WRITE_FIRST,
  parameter logic [DATA_W-1:0]  SINIT_A   = '0,
  parameter logic [DATA_W-1:0]  SINIT_B   = '0,
  parameter logic [DATA_W-1:0]  INIT_WORD = '0,
  parameter bit                 EN_HIGH   = 1'b1,
  parameter bit                 WE_HIGH   = 1'b1,
  parameter bit                 INIT_HIGH = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              a_en,
  input  logic              a_we,
  input  logic              a_init,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_en,
  input  logic              b_we,
  input  logic              b_init,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);

  localparam int NP = twp_pkg::NPORTS;
  localparam twp_pkg::wmode_e   MODE_SEL  [0:NP-1] = '{MODE_A, MODE_B};
  localparam logic [DATA_W-1:0] SINIT_SEL [0:NP-1] = '{SINIT_A, SINIT_B};

  logic               en_raw   [NP];
  logic               we_raw   [NP];
  logic               init_raw [NP];
  logic [DATA_W-1:0]  wdata    [NP];
  logic [DATA_W-1:0]  old      [NP];
  logic [DATA_W-1:0]  rdata    [NP];
  twp_pkg::port_cmd_t cmd      [NP];

  assign en_raw[0]   = a_en;
  assign we_raw[0]   = a_we;
  assign init_raw[0] = a_init;
  assign wdata[0]    = a_wdata;
  assign en_raw[1]   = b_en;
  assign we_raw[1]   = b_we;
  assign init_raw[1] = b_init;
  assign wdata[1]    = b_wdata;

  generate
    for (genvar p = 0; p < NP; p++) begin : g_port
      twp_port_ctl #(
        .EN_HIGH   (EN_HIGH),
        .WE_HIGH   (WE_HIGH),
        .INIT_HIGH (INIT_HIGH)
      ) u_ctl (
        .en_raw   (en_raw[p]),
        .we_raw   (we_raw[p]),
        .init_raw (init_raw[p]),
        .cmd      (cmd[p])
      );

      twp_dout_reg #(
        .DATA_W    (DATA_W),
        .MODE      (MODE_SEL[p]),
        .SINIT_VAL (SINIT_SEL[p])
      ) u_out (
        .clk  (clk),
        .rst  (rst),
        .cmd  (cmd[p]),
        .din  (wdata[p]),
        .old  (old[p]),
        .dout (rdata[p])
      );
    end
  endgenerate

  twp_array #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .INIT_WORD (INIT_WORD)
  ) u_mem (
    .clk    (clk),
    .wr_a   (cmd[0].wr),
    .addr_a (a_addr),
    .din_a  (a_wdata),
    .wr_b   (cmd[1].wr),
    .addr_b (b_addr),
    .din_b  (b_wdata),
    .old_a  (old[0]),
    .old_b  (old[1])
  );

  assign a_rdata = rdata[0];
  assign b_rdata = rdata[1];

endmodule

// File: rtl/dual_wmode_ram_chk.sv
`timescale 1ns/1ps
module dual_wmode_ram_chk #(
  parameter int                 DATA_W    = 32,
  parameter int                 ADDR_W    = 10,
  parameter twp_pkg::wmode_e    MODE_A    = twp_pkg::WM_WRITE_FIRST,
  parameter twp_pkg::wmode_e    MODE_B    = twp_pkg::WM_WRITE_FIRST,
  parameter logic [DATA_W-1:0]  SINIT_A   = '0,
  parameter logic [DATA_W-1:0]  SINIT_B   = '0,
  parameter bit                 EN_HIGH   = 1'b1,
  parameter bit                 WE_HIGH   = 1'b1,
  parameter bit                 INIT_HIGH = 1'b1
) (
  input logic              clk,
  input logic              rst,
  input logic              a_en,
  input logic              a_we,
  input logic              a_init,
  input logic [DATA_W-1:0] a_wdata,
  input logic [DATA_W-1:0] a_rdata,
  input logic              b_en,
  input logic              b_we,
  input logic              b_init,
  input logic [DATA_W-1:0] b_wdata,
  input logic [DATA_W-1:0] b_rdata
);

  logic a_on, a_wr, a_ini, b_on, b_wr, b_ini;
  assign a_on  = (a_en == EN_HIGH);
  assign a_wr  = (a_we == WE_HIGH);
  assign a_ini = (a_init == INIT_HIGH);
  assign b_on  = (b_en == EN_HIGH);
  assign b_wr  = (b_we == WE_HIGH);
  assign b_ini = (b_init == INIT_HIGH);

  // R1: reset loads the init constant of each port
  a_r1_reset_a: assert property (@(posedge clk) rst |=> a_rdata == SINIT_A);
  a_r1_reset_b: assert property (@(posedge clk) rst |=> b_rdata == SINIT_B);

  // R7: a disabled port keeps its output
  a_r7_hold_a: assert property (@(posedge clk) disable iff (rst)
    !a_on |=> $stable(a_rdata));
  a_r7_hold_b: assert property (@(posedge clk) disable iff (rst)
    !b_on |=> $stable(b_rdata));

  // R8: enabled init forces the constant
  a_r8_init_a: assert property (@(posedge clk) disable iff (rst)
    (a_on && a_ini) |=> a_rdata == SINIT_A);
  a_r8_init_b: assert property (@(posedge clk) disable iff (rst)
    (b_on && b_ini) |=> b_rdata == SINIT_B);

  generate
    if (MODE_A == twp_pkg::WM_WRITE_FIRST) begin : g_a_wf
      // R4: write-first shows the written data
      a_r4_wf_a: assert property (@(posedge clk) disable iff (rst)
        (a_on && a_wr && !a_ini) |=> a_rdata == $past(a_wdata));
    end else if (MODE_A == twp_pkg::WM_NO_CHANGE) begin : g_a_nc
      // R6: no-change keeps the output across a write
      a_r6_nc_a: assert property (@(posedge clk) disable iff (rst)
        (a_on && a_wr && !a_ini) |=> $stable(a_rdata));
    end
    if (MODE_B == twp_pkg::WM_WRITE_FIRST) begin : g_b_wf
      // R4
      a_r4_wf_b: assert property (@(posedge clk) disable iff (rst)
        (b_on && b_wr && !b_ini) |=> b_rdata == $past(b_wdata));
    end else if (MODE_B == twp_pkg::WM_NO_CHANGE) begin : g_b_nc
      // R6
      a_r6_nc_b: assert property (@(posedge clk) disable iff (rst)
        (b_on && b_wr && !b_ini) |=> $stable(b_rdata));
    end
  endgenerate

endmodule

bind dual_wmode_ram dual_wmode_ram_chk #(
  .DATA_W    (DATA_W),
  .ADDR_W    (ADDR_W),
  .MODE_A    (MODE_A),
  .MODE_B    (MODE_B),
  .SINIT_A   (SINIT_A),
  .SINIT_B   (SINIT_B),
  .EN_HIGH   (EN_HIGH),
  .WE_HIGH   (WE_HIGH),
  .INIT_HIGH (INIT_HIGH)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .a_en    (a_en),
  .a_we    (a_we),
  .a_init  (a_init),
  .a_wdata (a_wdata),
  .a_rdata (a_rdata),
  .b_en    (b_en),
  .b_we    (b_we),
  .b_init  (b_init),
  .b_wdata (b_wdata),
  .b_rdata (b_rdata)
);

// File: tb/sim_dual_wmode_ram.sv
`timescale 1ns/1ps
module sim_dual_wmode_ram;

  localparam int DW = 16;
  localparam int AW = 4;
  localparam int DEPTH = 1 << AW;

  typedef struct packed {
    logic [15:0]   tag;
    logic          ea, wa, ia;
    logic [AW-1:0] aa;
    logic [DW-1:0] da;
    logic          eb, wb, ib;
    logic [AW-1:0] ab;
    logic [DW-1:0] db;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [0:NV-1] = '{
    '{"R2",  1'b1,1'b0,1'b0,4'd3,16'h0000, 1'b1,1'b0,1'b0,4'd9,16'h0000},
    '{"R4",  1'b1,1'b1,1'b0,4'd3,16'h1111, 1'b1,1'b1,1'b0,4'd9,16'h2222},
    '{"R3",  1'b1,1'b0,1'b0,4'd9,16'h0000, 1'b1,1'b0,1'b0,4'd3,16'h0000},
    '{"R5",  1'b0,1'b0,1'b0,4'd0,16'h0000, 1'b1,1'b1,1'b0,4'd3,16'h3333},
    '{"R7",  1'b0,1'b1,1'b0,4'd5,16'hDEAD, 1'b1,1'b0,1'b0,4'd5,16'h0000},
    '{"R7",  1'b1,1'b0,1'b0,4'd5,16'h0000, 1'b0,1'b0,1'b0,4'd0,16'h0000},
    '{"R8",  1'b1,1'b1,1'b1,4'd6,16'h6666, 1'b1,1'b0,1'b0,4'd3,16'h0000},
    '{"R8",  1'b1,1'b0,1'b0,4'd6,16'h0000, 1'b1,1'b0,1'b1,4'd2,16'h0000},
    '{"R9",  1'b0,1'b0,1'b1,4'd6,16'h0000, 1'b0,1'b1,1'b1,4'd2,16'hBEEF},
    '{"R9",  1'b1,1'b0,1'b0,4'd2,16'h0000, 1'b1,1'b0,1'b0,4'd3,16'h0000},
    '{"R11", 1'b1,1'b0,1'b0,4'd3,16'h0000, 1'b1,1'b0,1'b0,4'd3,16'h0000},
    '{"R12", 1'b1,1'b1,1'b0,4'd7,16'hAAAA, 1'b1,1'b1,1'b0,4'd7,16'hBBBB},
    '{"R12", 1'b1,1'b0,1'b0,4'd7,16'h0000, 1'b1,1'b0,1'b0,4'd7,16'h0000},
    '{"R13", 1'b1,1'b1,1'b0,4'd8,16'h8888, 1'b1,1'b0,1'b0,4'd8,16'h0000},
    '{"R13", 1'b1,1'b0,1'b0,4'd8,16'h0000, 1'b1,1'b1,1'b0,4'd2,16'h0202},
    '{"R6",  1'b1,1'b1,1'b0,4'd4,16'h4444, 1'b1,1'b0,1'b0,4'd2,16'h0000},
    '{"R6",  1'b1,1'b0,1'b0,4'd4,16'h0000, 1'b1,1'b0,1'b0,4'd4,16'h0000},
    '{"R8",  1'b1,1'b0,1'b1,4'd9,16'h0000, 1'b1,1'b1,1'b0,4'd9,16'h9999},
    '{"R8",  1'b1,1'b0,1'b0,4'd9,16'h0000, 1'b1,1'b0,1'b0,4'd9,16'h0000}
  };

  localparam vec_t IDLE  = '{"R1", 1'b0,1'b0,1'b0,4'd0,16'h0000, 1'b0,1'b0,1'b0,4'd0,16'h0000};
  localparam vec_t RSTWR = '{"R1", 1'b1,1'b1,1'b0,4'd1,16'h1111, 1'b0,1'b0,1'b0,4'd0,16'h0000};
  localparam vec_t RDBK  = '{"R1", 1'b1,1'b0,1'b0,4'd1,16'h0000, 1'b1,1'b0,1'b0,4'd1,16'h0000};

  logic clk = 1'b0;
  logic rst;
  logic          a0_en, a0_we, a0_init, b0_en, b0_we, b0_init;
  logic          a1_en, a1_we, a1_init, b1_en, b1_we, b1_init;
  logic [AW-1:0] a_addr, b_addr;
  logic [DW-1:0] a_wdata, b_wdata;
  logic [DW-1:0] a0_rd, b0_rd, a1_rd, b1_rd;

  int n_cmp = 0;
  int n_bad = 0;

  twp_pkg::wmode_e bmode [2][2];
  logic [DW-1:0]   bsinit [2][2];
  logic [DW-1:0]   mdl [2][DEPTH];
  logic [DW-1:0]   expv [2][2];

  always #2 clk = ~clk;

  // u0: active-high controls, A write-first, B read-first, zero fill.
  dual_wmode_ram #(
    .DATA_W(DW), .ADDR_W(AW),
    .MODE_A(twp_pkg::WM_WRITE_FIRST), .MODE_B(twp_pkg::WM_READ_FIRST),
    .SINIT_A(16'hA5A5), .SINIT_B(16'h5A5A), .INIT_WORD(16'h0000),
    .EN_HIGH(1'b1), .WE_HIGH(1'b1), .INIT_HIGH(1'b1)
  ) u0 (
    .clk(clk), .rst(rst),
    .a_en(a0_en), .a_we(a0_we), .a_init(a0_init), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a0_rd),
    .b_en(b0_en), .b_we(b0_we), .b_init(b0_init), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b0_rd)
  );

  // u1: active-low controls, A no-change, B write-first, nonzero fill.
  dual_wmode_ram #(
    .DATA_W(DW), .ADDR_W(AW),
    .MODE_A(twp_pkg::WM_NO_CHANGE), .MODE_B(twp_pkg::WM_WRITE_FIRST),
    .SINIT_A(16'h0F0F), .SINIT_B(16'hF0F0), .INIT_WORD(16'h1234),
    .EN_HIGH(1'b0), .WE_HIGH(1'b0), .INIT_HIGH(1'b0)
  ) u1 (
    .clk(clk), .rst(rst),
    .a_en(a1_en), .a_we(a1_we), .a_init(a1_init), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a1_rd),
    .b_en(b1_en), .b_we(b1_we), .b_init(b1_init), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b1_rd)
  );

  function automatic logic [DW-1:0] port_next(input logic r, input twp_pkg::wmode_e m,
      input logic en, input logic we, input logic ini, input logic [DW-1:0] din,
      input logic [DW-1:0] old, input logic [DW-1:0] cur, input logic [DW-1:0] sv);
    if (r) return sv;
    if (!en) return cur;
    if (ini) return sv;
    if (we) begin
      if (m == twp_pkg::WM_WRITE_FIRST) return din;
      if (m == twp_pkg::WM_READ_FIRST)  return old;
      return cur;
    end
    return old;
  endfunction

  // R13: read data is undefined when the other port writes the same word.
  function automatic bit masked(input logic r, input twp_pkg::wmode_e m,
      input logic en, input logic we, input logic ini, input logic [AW-1:0] ad,
      input logic oen, input logic owe, input logic [AW-1:0] oad);
    if (r || !en || ini) return 1'b0;
    if (we && m != twp_pkg::WM_READ_FIRST) return 1'b0;
    return oen && owe && (ad == oad);
  endfunction

  task automatic check(input string tg, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tg, what, act, exp);
    end
  endtask

  task automatic apply(input vec_t v, input logic rv);
    bit ma [2];
    bit mb [2];
    string tg;
    @(negedge clk);
    rst = rv;
    a0_en = v.ea; a0_we = v.wa; a0_init = v.ia;
    b0_en = v.eb; b0_we = v.wb; b0_init = v.ib;
    a1_en = ~v.ea; a1_we = ~v.wa; a1_init = ~v.ia;
    b1_en = ~v.eb; b1_we = ~v.wb; b1_init = ~v.ib;
    a_addr = v.aa; a_wdata = v.da; b_addr = v.ab; b_wdata = v.db;
    for (int d = 0; d < 2; d++) begin
      logic [DW-1:0] oa;
      logic [DW-1:0] ob;
      oa = mdl[d][v.aa];
      ob = mdl[d][v.ab];
      ma[d] = masked(rv, bmode[d][0], v.ea, v.wa, v.ia, v.aa, v.eb, v.wb, v.ab);
      mb[d] = masked(rv, bmode[d][1], v.eb, v.wb, v.ib, v.ab, v.ea, v.wa, v.aa);
      expv[d][0] = port_next(rv, bmode[d][0], v.ea, v.wa, v.ia, v.da, oa, expv[d][0], bsinit[d][0]);
      expv[d][1] = port_next(rv, bmode[d][1], v.eb, v.wb, v.ib, v.db, ob, expv[d][1], bsinit[d][1]);
      // R12: port A is applied last so it wins a same-word double write.
      if (v.eb && v.wb) mdl[d][v.ab] = v.db;
      if (v.ea && v.wa) mdl[d][v.aa] = v.da;
    end
    @(posedge clk);
    #1;
    tg = $sformatf("%s", v.tag);
    if (!ma[0]) check(tg, "u0 port A", a0_rd, expv[0][0]);
    if (!mb[0]) check(tg, "u0 port B", b0_rd, expv[0][1]);
    if (!ma[1]) check({tg, "+R10"}, "u1 port A", a1_rd, expv[1][0]);
    if (!mb[1]) check({tg, "+R10"}, "u1 port B", b1_rd, expv[1][1]);
  endtask

  initial begin
    rst = 1'b1;
    a0_en = 1'b0; a0_we = 1'b0; a0_init = 1'b0;
    b0_en = 1'b0; b0_we = 1'b0; b0_init = 1'b0;
    a1_en = 1'b1; a1_we = 1'b1; a1_init = 1'b1;
    b1_en = 1'b1; b1_we = 1'b1; b1_init = 1'b1;
    a_addr = '0; b_addr = '0; a_wdata = '0; b_wdata = '0;
    bmode[0][0] = twp_pkg::WM_WRITE_FIRST; bmode[0][1] = twp_pkg::WM_READ_FIRST;
    bmode[1][0] = twp_pkg::WM_NO_CHANGE;   bmode[1][1] = twp_pkg::WM_WRITE_FIRST;
    bsinit[0][0] = 16'hA5A5; bsinit[0][1] = 16'h5A5A;
    bsinit[1][0] = 16'h0F0F; bsinit[1][1] = 16'hF0F0;
    for (int i = 0; i < DEPTH; i++) begin
      mdl[0][i] = 16'h0000;
      mdl[1][i] = 16'h1234;
    end
    for (int d = 0; d < 2; d++) begin
      expv[d][0] = 'x;
      expv[d][1] = 'x;
    end

    // R1: reset state of both read registers
    apply(IDLE, 1'b1);
    apply(IDLE, 1'b1);

    // Table of stimulus, expectations from the bench model
    for (int i = 0; i < NV; i++) apply(VEC[i], 1'b0);

    // R1: reset mid-run overrides a write on the output but the write is kept
    apply(RSTWR, 1'b1);
    apply(RDBK, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #800000;
    n_bad++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule